// File: doc/BRIEF.md
# Daisy-Chained TDM Audio Slot Receiver

This block takes one serial time-division-multiplexed audio stream that several receivers share, and keeps only the slots that belong to its own device. It samples the data line on each rising edge of the bit clock. A frame-sync pulse marks the most significant bit of slot 0. From that point every slot is 32 bit cycles long. Only the upper 24 bits of each slot carry the audio sample, and those bits are returned as a parallel word.

Slot numbers are not fixed in advance. The receivers pass a token down a chain instead. When the chain input is high on the last bit of a slot, the device takes the following slot. It then keeps as many consecutive slots as it has enabled channels, and fills them in ascending channel order. The chain output is high for the whole of the device's last owned slot, which hands the token to the next device. A device with no enabled channel wires its chain input straight to its chain output.

The channel-enable mask is captured at each frame sync. For every owned slot, the block gives one output cycle holding the word, a valid strobe and the channel index.

Top module: `tdm_chain_rx`

## Requirements
- R1: After reset and before the first frame sync, `word_valid` stays low. During that time the captured enable mask is empty, so `chain_out` follows `chain_in`.
- R2: The cycle in which `frame_sync` is high carries bit 31 (the MSB) of slot 0. Each slot is 32 bits, sent MSB first. For an owned slot, slot bits 31..8 appear on `word_out` in the cycle after the slot's 32nd bit, and `word_valid` is high for exactly that one cycle.
- R3: Slot bits 7..0 have no effect on any output, whatever their value.
- R4: A device with K > 0 enabled channels starts owning at a slot start when two conditions hold: `chain_in` was high in the previous bit cycle, and the device has not yet started or finished an allocation in the current frame. It then owns K consecutive slots.
- R5: The j-th owned slot of an allocation (j from 0) reports `word_chan` equal to the bit position of the j-th set bit of the captured enable mask, counting from bit 0 upward.
- R6: When K > 0, `chain_out` is high in every bit cycle of the last owned slot of the allocation and low in every other slot.
- R7: When K = 0, `chain_out` equals `chain_in` in the same cycle.
- R8: Once the allocation of a frame has ended, a further high level on `chain_in` in that frame grants nothing: it produces no word and no `chain_out` pulse.
- R9: A frame sync ends any allocation still in progress, so slots that did not fit into the frame are never owned. A token seen on the bit just before the frame sync grants slot 0 of the new frame.
- R10: `chan_en` is captured in the frame-sync cycle. Changing it in the middle of a frame alters neither ownership, nor channel indices, nor `chain_out` until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | High for one bit cycle on the MSB of slot 0 |
| sdata | input | 1 | Serial audio data, MSB first |
| chain_in | input | 1 | Token from the previous device in the chain |
| chan_en | input | NCH | Per-channel enable mask, captured at frame sync |
| chain_out | output | 1 | Token to the next device |
| word_out | output | WORD_W | Received audio word |
| word_valid | output | 1 | High for one cycle when `word_out` is new |
| word_chan | output | CW | Channel index of `word_out` |

## Verification
The assertions assume that all inputs are synchronous to the bit clock and that a frame holds at least one full slot before the next frame sync. They do not assume that `chan_en` is stable, because the block captures it at frame start. The bench changes its inputs only at falling edges. It sends whole frames of six slots separated by a single idle bit, and that idle bit also carries the token for slot 0 of the next frame. Random masks, token patterns and data, including nonzero filler bits and enable changes in mid-frame, stay within these limits.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;

  // Number of set bits in a mask of up to 32 channels.
  function automatic logic [5:0] count_ones(logic [31:0] v);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + {5'd0, v[i]};
    return n;
  endfunction

  // Position of the k-th set bit (k from 0), scanning upward from bit 0.
  function automatic logic [4:0] nth_set(logic [31:0] v, logic [4:0] k);
    logic [5:0] seen;
    logic [4:0] pos;
    seen = '0;
    pos  = '0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) begin
        if (seen == {1'b0, k}) pos = 5'(i);
        seen = seen + 6'd1;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/tdm_slot_framer.sv
module tdm_slot_framer #(
  parameter int SLOT_W = 32,
  parameter int WORD_W = 24,
  localparam int BW = $clog2(SLOT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              sdata,
  output logic              slot_start,
  output logic              slot_end,
  output logic [WORD_W-1:0] slot_word
);

  localparam logic [BW-1:0] LAST_BIT = BW'(SLOT_W - 1);

  logic [BW-1:0]     bpos;
  logic              synced;
  logic [SLOT_W-2:0] shreg;

  // Audio sits in the top of the slot; the filler below is dropped.
  function automatic logic [WORD_W-1:0] upper_field(logic [SLOT_W-1:0] s);
    return s[SLOT_W-1 -: WORD_W];
  endfunction

  assign slot_start = frame_sync || (synced && bpos == '0);
  assign slot_end   = synced && !frame_sync && bpos == LAST_BIT;
  assign slot_word  = upper_field({shreg, sdata});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpos   <= '0;
      synced <= 1'b0;
      shreg  <= '0;
    end else begin
      shreg <= {shreg[SLOT_W-3:0], sdata};
      if (frame_sync) begin
        synced <= 1'b1;
        bpos   <= BW'(1);
      end else if (synced) begin
        bpos <= (bpos == LAST_BIT) ? '0 : bpos + BW'(1);
      end
    end
  end

  // R2
  slot_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> slot_start);

endmodule

// File: rtl/tdm_chain_owner.sv
module tdm_chain_owner
  import tdm_chain_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_sync,
  input  logic           slot_start,
  input  logic           slot_end,
  input  logic           chain_in,
  input  logic [NCH-1:0] chan_en,
  output logic           chain_out,
  output logic           emit,
  output logic [CW-1:0]  emit_chan
);

  logic           own_q, done_q, cin_q;
  logic [CW-1:0]  k_q;
  logic [NCH-1:0] en_q;

  logic [NCH-1:0] en_eff;
  logic [CW:0]    nact;
  logic           base_own, base_done;
  logic           nxt_own, nxt_done;
  logic [CW-1:0]  nxt_k;
  logic           cur_own, cur_done;
  logic [CW-1:0]  cur_k;
  logic           grant_evt;
  logic           alloc_last;

  // Enable mask in force for this cycle: the live one at frame start.
  assign en_eff    = frame_sync ? chan_en : en_q;
  assign nact      = (CW+1)'(count_ones(32'(en_eff)));
  assign base_own  = frame_sync ? 1'b0 : own_q;
  assign base_done = frame_sync ? 1'b0 : done_q;
  assign grant_evt = slot_start && !base_own && !base_done && cin_q && nact != '0;

  always_comb begin
    nxt_own  = base_own;
    nxt_done = base_done;
    nxt_k    = k_q;
    if (base_own) begin
      if (({1'b0, k_q} + 1'b1) < nact) begin
        nxt_k = k_q + 1'b1;
      end else begin
        nxt_own  = 1'b0;
        nxt_done = 1'b1;
      end
    end else if (grant_evt) begin
      nxt_own = 1'b1;
      nxt_k   = '0;
    end
  end

  assign cur_own  = slot_start ? nxt_own  : own_q;
  assign cur_done = slot_start ? nxt_done : done_q;
  assign cur_k    = slot_start ? nxt_k    : k_q;

  assign alloc_last = cur_own && (({1'b0, cur_k} + 1'b1) == nact);
  assign chain_out  = (nact == '0) ? chain_in : alloc_last;

  assign emit      = slot_end && own_q;
  assign emit_chan = CW'(nth_set(32'(en_q), 5'(k_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= 1'b0;
      done_q <= 1'b0;
      k_q    <= '0;
      en_q   <= '0;
      cin_q  <= 1'b0;
    end else begin
      own_q  <= cur_own;
      done_q <= cur_done;
      k_q    <= cur_k;
      en_q   <= en_eff;
      cin_q  <= chain_in;
    end
  end

  // R4
  alloc_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_own |-> ({1'b0, cur_k} < nact));

  // R4
  token_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_q) |-> $past(cin_q));

  // R5
  emit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> en_q[emit_chan]);

endmodule

// File: rtl/tdm_chain_rx.sv
module tdm_chain_rx #(
  parameter int NCH    = 4,
  parameter int SLOT_W = 32,
  parameter int WORD_W = 24,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              sdata,
  input  logic              chain_in,
  input  logic [NCH-1:0]    chan_en,
  output logic              chain_out,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic [CW-1:0]     word_chan
);

  logic              slot_start, slot_end, emit;
  logic [WORD_W-1:0] slot_word;
  logic [CW-1:0]     emit_chan;

  tdm_slot_framer #(.SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .sdata      (sdata),
    .slot_start (slot_start),
    .slot_end   (slot_end),
    .slot_word  (slot_word)
  );

  tdm_chain_owner #(.NCH(NCH)) u_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .slot_start (slot_start),
    .slot_end   (slot_end),
    .chain_in   (chain_in),
    .chan_en    (chan_en),
    .chain_out  (chain_out),
    .emit       (emit),
    .emit_chan  (emit_chan)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_out   <= '0;
      word_chan  <= '0;
    end else begin
      word_valid <= emit;
      if (emit) begin
        word_out  <= slot_word;
        word_chan <= emit_chan;
      end
    end
  end

  // R2
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

endmodule

// File: tb/tdm_chain_rx_test.sv
`timescale 1ns/1ps
module tdm_chain_rx_test;

  localparam int NCH = 4;
  localparam int NS  = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           frame_sync = 1'b0;
  logic           sdata = 1'b0;
  logic           chain_in = 1'b0;
  logic [NCH-1:0] chan_en = '0;
  logic           chain_out;
  logic [23:0]    word_out;
  logic           word_valid;
  logic [1:0]     word_chan;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic        pend_v = 1'b0;
  logic [23:0] pend_w = '0;
  int          pend_c = 0;

  always #2 clk = ~clk;

  tdm_chain_rx uut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .sdata(sdata),
    .chain_in(chain_in), .chan_en(chan_en), .chain_out(chain_out),
    .word_out(word_out), .word_valid(word_valid), .word_chan(word_chan)
  );

  function automatic int popc(logic [NCH-1:0] m);
    int n = 0;
    for (int i = 0; i < NCH; i++) if (m[i]) n++;
    return n;
  endfunction

  // Channel of the j-th owned slot: walk up the mask skipping cleared bits.
  function automatic int chan_of(logic [NCH-1:0] m, int j);
    int left = j;
    for (int i = 0; i < NCH; i++) begin
      if (m[i]) begin
        if (left == 0) return i;
        left--;
      end
    end
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_word();
    chk("R2 valid", {31'd0, word_valid}, {31'd0, pend_v});
    if (pend_v) begin
      chk("R2 R3 word", {8'd0, word_out}, {8'd0, pend_w});
      chk("R5 chan", {30'd0, word_chan}, 32'(pend_c));
    end
    pend_v = 1'b0;
  endtask

  task automatic run_frame(input logic [NCH-1:0] en_f, input logic [NCH-1:0] en_mid,
                           input logic pre, input logic [NS-1:0] toks);
    logic [31:0] d;
    logic own = 0, done = 0, tprev;
    int k = 0;
    int kk = popc(en_f);
    logic exp_co;
    // idle bit: carries the token for slot 0
    @(negedge clk);
    frame_sync = 1'b0; chain_in = pre; chan_en = en_f; sdata = 1'($urandom);
    #1 check_word();
    tprev = pre;
    for (int s = 0; s < NS; s++) begin
      d = $urandom;
      if (own) begin
        if (k + 1 < kk) k++;
        else begin own = 0; done = 1; end
      end else if (!done && tprev && kk > 0) begin
        own = 1; k = 0;
      end
      exp_co = (kk == 0) ? toks[s] : (own && k == kk - 1);
      for (int b = 0; b < 32; b++) begin
        @(negedge clk);
        frame_sync = (s == 0 && b == 0);
        sdata = d[31-b];
        chain_in = toks[s];
        if (s == 2 && b == 5) chan_en = en_mid; // R10
        #1;
        check_word();
        if (b == 0 || b == 31)
          chk((kk == 0) ? "R7 passthru" : "R6 R8 R9 chain_out",
              {31'd0, chain_out}, {31'd0, exp_co});
      end
      if (own) begin
        pend_v = 1'b1; pend_w = d[31:8]; pend_c = chan_of(en_f, k);
      end
      tprev = toks[s];
    end
  endtask

  initial begin
    // R1: reset state and pre-frame pass-through
    chan_en = 4'b0101; chain_in = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset valid", {31'd0, word_valid}, 32'd0);
    chk("R1 reset chain_out", {31'd0, chain_out}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chain_in = 1'($urandom); sdata = 1'($urandom);
      #1;
      chk("R1 pre-frame valid", {31'd0, word_valid}, 32'd0);
      chk("R1 pre-frame chain_out", {31'd0, chain_out}, {31'd0, chain_in});
    end
    // R4 R5 R6: all channels, token before slot 0
    run_frame(4'b1111, 4'b1111, 1'b1, 6'b000000);
    // R7: no channel, chain passes through
    run_frame(4'b0000, 4'b0000, 1'b0, 6'b101101);
    // R8: second token after the allocation is done
    run_frame(4'b0110, 4'b0110, 1'b0, 6'b010010);
    // R9: allocation cut by the frame end, then no token for slot 0
    run_frame(4'b1011, 4'b1011, 1'b0, 6'b001000);
    run_frame(4'b1011, 4'b1011, 1'b0, 6'b000000);
    // R10: mask widened mid-frame has no effect
    run_frame(4'b0001, 4'b1111, 1'b1, 6'b000000);
    run_frame(4'b1000, 4'b0000, 1'b0, 6'b000001);
    // random frames
    for (int f = 0; f < 24; f++)
      run_frame(4'($urandom), 4'($urandom), 1'($urandom), 6'($urandom));
    @(negedge clk);
    frame_sync = 1'b0; #1 check_word();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule